// File: doc/BRIEF.md
# Down-Counting Timer with APB Register Access

This block is a memory-mapped down-counter that a processor programs over an APB slave port. Software writes a reload value and a start value, then sets a run bit. From then on the counter steps down by one on each tick. When it steps from one to zero it raises a sticky event flag. On the next tick it reloads from the reload register and keeps counting. The event flag drives an interrupt line through an enable mask. Software clears the flag with a write.

A single external input can drive the timer in two ways. As a gate, it lets the counter advance on system clock cycles only while the input is high. As a clock source, it advances the counter once per rising edge. The input always passes through a synchroniser before use. The tick source is chosen by a combinational mode decoder with four named modes:
- MODE_HALT: no ticks.
- MODE_FREE: a tick on every clock.
- MODE_GATED: a tick on every clock while the synchronised input is high.
- MODE_EDGE: a tick on each detected rising edge.

The mode follows the control bits on every cycle (run, external enable, edge select), so every mode can be reached from every other by one control write.

Top module: `apb_countdown_timer`

## Requirements
- R1: After reset, the control, value, reload and flag locations all read 0, and `irq` is 0.
- R2: APB transfers complete with no wait states (`pready` = 1). The register word is selected by `paddr[3:2]` and `paddr` bits above 3 must be 0; any other address reads 0. The locations are 0x00 control, 0x04 current value, 0x08 reload and 0x0C flag. Control and reload read back what was written. Control bits 31:4 read 0.
- R3: With control bit 0 set and bits 1 and 2 clear (MODE_FREE), the value decrements by one on every clock edge, starting with the edge after the control write.
- R4: With control bit 0 clear (MODE_HALT), the value holds.
- R5: A tick with value 1 sets the value to 0 and sets the flag. A tick with value 0 loads the reload register.
- R6: With bits 0 and 1 set and bit 2 clear (MODE_GATED), the value decrements on each clock only while `ext_in`, after two synchroniser flops, is high. A low input stops the count.
- R7: With bits 0 and 2 set (MODE_EDGE, bit 1 ignored), the value decrements exactly once per rising edge of the synchronised `ext_in`.
- R8: A write to 0x04 loads the counter with the written data. If a tick falls in the same cycle, the write takes priority.
- R9: The flag reads at bit 0 of 0x0C. Writing 1 to bit 0 of 0x0C clears it. Writing 0 leaves it set.
- R10: When a 1→0 step and a clear write fall in the same cycle, the flag ends up set.
- R11: `irq` equals the flag ANDed with control bit 3. The flag is set whether or not bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | System clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always high, no wait states |
| ext_in | input | 1 | Asynchronous external gate or clock input |
| irq | output | 1 | Masked interrupt output |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is a counter step from one to zero and a flag-clear write. The bench provokes this by enabling the timer with value 2 and issuing the clear write at once, so the clear's write edge is the edge that reaches zero. It then judges the flag by reading it back, expecting it set. It also checks the value, which must show the reload and then one further step.

The second pair is a software load and a running tick. The bench writes a new value while the timer runs, and the next read must show that value minus one, not the old count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned CTRL_BITS = 4;

    typedef enum logic [1:0] {
        WORD_CTRL   = 2'd0,
        WORD_VALUE  = 2'd1,
        WORD_RELOAD = 2'd2,
        WORD_FLAG   = 2'd3
    } word_sel_e;

    typedef enum logic [1:0] {
        MODE_HALT,
        MODE_FREE,
        MODE_GATED,
        MODE_EDGE
    } count_mode_e;

    typedef struct packed {
        logic irq_en;
        logic edge_clk;
        logic ext_en;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/tmr_input_sync.sv
module tmr_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tmr_tick_select.sv
module tmr_tick_select
    import tmr_pkg::*;
(
    input  ctrl_t       ctrl,
    input  logic        ext_level,
    input  logic        ext_rise,
    output count_mode_e mode,
    output logic        tick
);
    always_comb begin
        if (!ctrl.run)         mode = MODE_HALT;
        else if (ctrl.edge_clk) mode = MODE_EDGE;
        else if (ctrl.ext_en)   mode = MODE_GATED;
        else                    mode = MODE_FREE;
    end

    always_comb begin
        unique case (mode)
            MODE_HALT:  tick = 1'b0;
            MODE_FREE:  tick = 1'b1;
            MODE_GATED: tick = ext_level;
            MODE_EDGE:  tick = ext_rise;
            default:    tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load_en,
    input  logic [W-1:0] load_data,
    input  logic [W-1:0] reload,
    input  logic         clr_req,
    output logic [W-1:0] value,
    output logic         flag
);
    localparam logic [W-1:0] ONE = W'(1);

    logic step;
    logic hit_zero;

    assign step     = tick & ~load_en;
    assign hit_zero = step & (value == ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             value <= '0;
        else if (load_en)       value <= load_data;
        else if (step) begin
            if (value == '0)    value <= reload;
            else                value <= value - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (hit_zero) flag <= 1'b1;
        else if (clr_req)  flag <= 1'b0;
    end
endmodule

// File: rtl/apb_countdown_timer.sv
module apb_countdown_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    input  logic              ext_in,
    output logic              irq
);
    localparam int WORD_LSB = 2;
    localparam int WORD_MSB = WORD_LSB + 1;

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] value;
    logic              flag;
    logic              ext_level;
    logic              ext_rise;
    logic              tick;
    count_mode_e       mode;
    word_sel_e         word;
    logic              in_range;
    logic              wr_en;
    logic              load_en;
    logic              clr_req;

    assign word     = word_sel_e'(paddr[WORD_MSB:WORD_LSB]);
    assign in_range = (paddr[ADDR_W-1:WORD_MSB+1] == '0);
    assign wr_en    = psel & penable & pwrite & in_range;
    assign load_en  = wr_en & (word == WORD_VALUE);
    assign clr_req  = wr_en & (word == WORD_FLAG) & pwdata[0];
    assign pready   = 1'b1;

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            ctrl_q   <= '0;
            reload_q <= '0;
        end else if (wr_en) begin
            if (word == WORD_CTRL)   ctrl_q   <= ctrl_t'(pwdata[CTRL_BITS-1:0]);
            if (word == WORD_RELOAD) reload_q <= pwdata;
        end
    end

    always_comb begin
        prdata = '0;
        if (in_range) begin
            unique case (word)
                WORD_CTRL:   prdata = DATA_W'(ctrl_q);
                WORD_VALUE:  prdata = value;
                WORD_RELOAD: prdata = reload_q;
                WORD_FLAG:   prdata = DATA_W'(flag);
                default:     prdata = '0;
            endcase
        end
    end

    assign irq = flag & ctrl_q.irq_en;

    tmr_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (pclk),
        .rst_n    (presetn),
        .async_in (ext_in),
        .level    (ext_level),
        .rise     (ext_rise)
    );

    tmr_tick_select u_tick (
        .ctrl      (ctrl_q),
        .ext_level (ext_level),
        .ext_rise  (ext_rise),
        .mode      (mode),
        .tick      (tick)
    );

    tmr_counter #(.W(DATA_W)) u_counter (
        .clk       (pclk),
        .rst_n     (presetn),
        .tick      (tick),
        .load_en   (load_en),
        .load_data (pwdata),
        .reload    (reload_q),
        .clr_req   (clr_req),
        .value     (value),
        .flag      (flag)
    );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         load_en,
    input logic [W-1:0] load_data,
    input logic [W-1:0] value,
    input logic [W-1:0] reload,
    input logic         flag,
    input logic         irq_en,
    input logic         irq
);
    localparam logic [W-1:0] ONE = W'(1);

    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en && value > ONE) |=> value == $past(value) - ONE);

    p_wrap_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en && value == '0) |=> value == $past(reload));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en) |=> $stable(value));

    p_sw_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> value == $past(load_data));

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en && value == ONE) |=> flag);
endmodule

bind apb_countdown_timer tmr_checker #(.W(DATA_W)) u_tmr_checker (
    .clk       (pclk),
    .rst_n     (presetn),
    .tick      (tick),
    .load_en   (load_en),
    .load_data (pwdata),
    .value     (value),
    .reload    (reload_q),
    .flag      (flag),
    .irq_en    (ctrl_q.irq_en),
    .irq       (irq)
);

// File: tb/test_apb_countdown_timer.sv
module test_apb_countdown_timer;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 12;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 12'h008, 32'hDEADBEEF},
        '{1'b0, 12'h008, 32'hDEADBEEF},
        '{1'b1, 12'h000, 32'hFFFFFFF6},
        '{1'b0, 12'h000, 32'h00000006},
        '{1'b1, 12'h000, 32'h00000000},
        '{1'b1, 12'h004, 32'h12345678},
        '{1'b0, 12'h004, 32'h12345678},
        '{1'b0, 12'h01C, 32'h00000000},
        '{1'b0, 12'h00C, 32'h00000000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [DW-1:0] prdata;
    logic          pready;
    logic          ext_in = 1'b0;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    apb_countdown_timer i_apb_countdown_timer (
        .pclk    (clk),
        .presetn (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .pready  (pready),
        .ext_in  (ext_in),
        .irq     (irq)
    );

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic apb_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        check("R2 pready", {31'b0, pready}, 32'd1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ext(input int n);
        for (int i = 0; i < n; i++) begin
            ext_in = 1'b1; idle(4);
            ext_in = 1'b0; idle(4);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        apb_read(12'h000, rd); check("R1 ctrl", rd, 0);
        apb_read(12'h004, rd); check("R1 value", rd, 0);
        apb_read(12'h008, rd); check("R1 reload", rd, 0);
        apb_read(12'h00C, rd); check("R1 flag", rd, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R2 register table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].wr) apb_write(VEC[i].addr, VEC[i].data);
            else begin
                apb_read(VEC[i].addr, rd);
                check("R2 table", rd, VEC[i].data);
            end
        end

        // R3 free running, R4 halt
        apb_write(12'h004, 100);
        apb_write(12'h000, 1);
        apb_read(12'h004, rd); check("R3 first step", rd, 99);
        apb_write(12'h000, 0);
        apb_read(12'h004, rd); check("R3 stepped count", rd, 96);
        idle(20);
        apb_read(12'h004, rd); check("R4 halted hold", rd, 96);

        // R5 wrap and reload, R11 masking, R9 clear
        apb_write(12'h008, 5);
        apb_write(12'h004, 3);
        apb_write(12'h000, 1);
        idle(3);
        apb_write(12'h000, 0);
        apb_read(12'h004, rd); check("R5 wrap reload", rd, 4);
        apb_read(12'h00C, rd); check("R5 flag set", rd, 1);
        check("R11 irq masked", {31'b0, irq}, 0);
        apb_write(12'h000, 8);
        check("R11 irq enabled", {31'b0, irq}, 1);
        apb_write(12'h00C, 0);
        apb_read(12'h00C, rd); check("R9 write 0 keeps flag", rd, 1);
        apb_write(12'h00C, 1);
        apb_read(12'h00C, rd); check("R9 clear", rd, 0);
        check("R9 irq low after clear", {31'b0, irq}, 0);
        apb_write(12'h000, 0);

        // R8 software load beats tick
        apb_write(12'h004, 500);
        apb_write(12'h000, 1);
        apb_write(12'h004, 1000);
        apb_read(12'h004, rd); check("R8 load over tick", rd, 999);
        apb_write(12'h000, 0);

        // R6 gated mode
        apb_write(12'h004, 50);
        apb_write(12'h000, 3);
        idle(10);
        apb_write(12'h000, 0);
        apb_read(12'h004, rd); check("R6 gate low", rd, 50);
        ext_in = 1'b1;
        idle(5);
        apb_write(12'h000, 3);
        idle(4);
        apb_write(12'h000, 0);
        apb_read(12'h004, rd); check("R6 gate high", rd, 44);
        ext_in = 1'b0;
        idle(5);

        // R7 edge mode
        apb_write(12'h004, 20);
        apb_write(12'h000, 5);
        idle(2);
        pulse_ext(3);
        idle(5);
        apb_write(12'h000, 0);
        apb_read(12'h004, rd); check("R7 three edges", rd, 17);
        apb_write(12'h000, 7);
        idle(2);
        pulse_ext(2);
        idle(5);
        apb_write(12'h000, 0);
        apb_read(12'h004, rd); check("R7 bit1 ignored", rd, 15);

        // R10 zero step and clear on the same edge
        apb_write(12'h008, 10);
        apb_write(12'h004, 2);
        apb_write(12'h000, 1);
        apb_write(12'h00C, 1);
        apb_write(12'h000, 0);
        apb_read(12'h00C, rd); check("R10 set wins", rd, 1);
        apb_read(12'h004, rd); check("R10 value after reload", rd, 9);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule